// File: doc/BRIEF.md
# Coherent Byte-Access 16-bit Register Bridge

This block sits between an 8-bit register bus and a 16-bit pulse timer. It holds two writable 16-bit settings, a period value and a duty value, and exposes the timer's running count for reading. Software can reach every 16-bit quantity either with one wide transfer or with two byte transfers. The bridge makes sure that the timer never picks up a half-updated setting, and that software never sees a count torn across two different moments.

A byte-wise update of a setting goes upper byte first. The upper byte is parked in a staging register. The committed value changes only when the lower byte arrives. The timer reloads from the committed period value. It raises a load strobe at each reload, and on that strobe the bridge moves the committed duty value into the active duty register that the comparator uses. Reading the upper byte of the count also captures the count's lower byte, so the next lower-byte read returns a value from the same cycle.

Every access is accepted in the cycle it is presented. There is no back-pressure, and no ready signal exists. Read data appears one clock after the read strobe and holds until the next read.

Top module: `cnt_reg_bridge`

## Requirements
- R1: After reset the committed period value is 0xFFFF, the active duty value is 0xFFFF, the committed duty value is 0xFFFF, the count low-byte holding register is 0x00, and read data is 0x0000.
- R2: A byte write (bus_wide=0) to a setting's upper-byte address (period 0, duty 2) leaves the committed value unchanged. The next byte write to the matching lower-byte address (period 1, duty 3) commits {staged upper byte, new lower byte}. A byte write carries its data in bus_wdata[7:0].
- R3: A wide access (bus_wide=1) at an upper-byte address covers all 16 bits. A wide write commits bus_wdata in one clock. A wide read returns the full 16-bit value.
- R4: A byte read of the count's upper byte (address 4) returns live_count[15:8] and captures live_count[7:0]. A later byte read of the count's lower byte (address 5) returns that captured byte, even if live_count has since changed. A wide read at address 4 does not change the captured byte.
- R5: Writes to the count addresses 4 and 5 have no effect on any committed setting, on the active duty value, or on the captured low byte.
- R6: The active duty value changes only in a clock where cnt_load is high. It then takes the committed duty value as it stood before that edge, so a lower-byte write in the same clock as the load is not yet seen.
- R7: A load that falls between the upper-byte write and the lower-byte write of a duty update transfers the previously committed duty value.
- R8: A lower-byte write with no staged upper byte pending combines the new lower byte with the current committed upper byte.
- R9: Read data is registered. It is valid in the clock after bus_rd and holds until the next read. A byte read returns the byte zero-extended in bits 7:0. Reads of a setting return the committed value, never the staged byte. Unmapped addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address: 0/1 period upper/lower, 2/3 duty upper/lower, 4/5 count upper/lower |
| bus_wdata | input | 16 | Write data; bits 7:0 for byte writes, all bits for wide writes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wide | input | 1 | Marks the access as one 16-bit transfer at the upper-byte address |
| live_count | input | 16 | Running count from the timer |
| cnt_load | input | 1 | Timer reload strobe |
| rd_data | output | 16 | Registered read data |
| cycle_val | output | 16 | Committed period value used by the timer's reload |
| duty_active | output | 16 | Active duty value used by the comparator |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. Committed values, the active duty value, the captured count byte and read data all update on the edge that samples the strobes. The bench applies each access just after a falling edge and compares all three outputs at the following falling edge, half a period after the edge that acted on them. Ordering cases, such as a load placed between the two byte writes or in the same clock as the lower-byte write, are driven as consecutive single-clock steps, so each expected value follows from the previous edge alone.

// File: rtl/rb_pkg.sv
package rb_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CYC_HI  = 3'd0,
    A_CYC_LO  = 3'd1,
    A_DUTY_HI = 3'd2,
    A_DUTY_LO = 3'd3,
    A_CNT_HI  = 3'd4,
    A_CNT_LO  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic wide;
    logic hi_byte;
    logic lo_byte;
  } wr_ctl_t;

endpackage

// File: rtl/staged_word_reg.sv
module staged_word_reg #(
  parameter int          WORD_W     = 16,
  parameter logic [WORD_W-1:0] RESET_VAL = '1,
  parameter bit          HAS_SHADOW = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rb_pkg::wr_ctl_t     ctl,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                load,
  output logic [WORD_W-1:0]   committed,
  output logic [WORD_W-1:0]   active
);
  localparam int BYTE_W = WORD_W / 2;

  logic [BYTE_W-1:0] stage_hi;
  logic              pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      committed <= RESET_VAL;
      stage_hi  <= '0;
      pend      <= 1'b0;
    end else if (ctl.wide) begin
      committed <= wdata;
      pend      <= 1'b0;
    end else if (ctl.hi_byte) begin
      stage_hi  <= wdata[BYTE_W-1:0];
      pend      <= 1'b1;
    end else if (ctl.lo_byte) begin
      committed <= {(pend ? stage_hi : committed[WORD_W-1:BYTE_W]),
                    wdata[BYTE_W-1:0]};
      pend      <= 1'b0;
    end
  end

  generate
    if (HAS_SHADOW) begin : g_shadow
      logic [WORD_W-1:0] shadow_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    shadow_q <= RESET_VAL;
        else if (load) shadow_q <= committed;
      end
      assign active = shadow_q;
    end else begin : g_direct
      logic unused_load;
      assign unused_load = load;
      assign active = committed;
    end
  endgenerate
endmodule

// File: rtl/count_snap_reader.sv
module count_snap_reader #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap,
  input  logic [BYTE_W-1:0] live_lo,
  output logic [BYTE_W-1:0] held_lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_lo <= '0;
    else if (snap) held_lo <= live_lo;
  end
endmodule

// File: rtl/cnt_reg_bridge.sv
module cnt_reg_bridge #(
  parameter int WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [rb_pkg::ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0]         bus_wdata,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic                      bus_wide,
  input  logic [WORD_W-1:0]         live_count,
  input  logic                      cnt_load,
  output logic [WORD_W-1:0]         rd_data,
  output logic [WORD_W-1:0]         cycle_val,
  output logic [WORD_W-1:0]         duty_active
);
  import rb_pkg::*;
  localparam int BYTE_W = WORD_W / 2;

  wr_ctl_t           cyc_ctl, duty_ctl;
  logic [WORD_W-1:0] duty_commit;
  logic [WORD_W-1:0] cyc_active_unused;
  logic [BYTE_W-1:0] held_lo;
  logic              snap_hi;
  logic [WORD_W-1:0] rd_next;

  always_comb begin
    cyc_ctl  = '0;
    duty_ctl = '0;
    if (bus_wr) begin
      cyc_ctl.wide     = bus_wide  && (bus_addr == A_CYC_HI);
      cyc_ctl.hi_byte  = !bus_wide && (bus_addr == A_CYC_HI);
      cyc_ctl.lo_byte  = !bus_wide && (bus_addr == A_CYC_LO);
      duty_ctl.wide    = bus_wide  && (bus_addr == A_DUTY_HI);
      duty_ctl.hi_byte = !bus_wide && (bus_addr == A_DUTY_HI);
      duty_ctl.lo_byte = !bus_wide && (bus_addr == A_DUTY_LO);
    end
  end

  assign snap_hi = bus_rd && !bus_wide && (bus_addr == A_CNT_HI);

  staged_word_reg #(.WORD_W(WORD_W), .RESET_VAL('1), .HAS_SHADOW(1'b0)) i_cyc (
    .clk(clk), .rst_n(rst_n), .ctl(cyc_ctl), .wdata(bus_wdata), .load(cnt_load),
    .committed(cycle_val), .active(cyc_active_unused)
  );

  staged_word_reg #(.WORD_W(WORD_W), .RESET_VAL('1), .HAS_SHADOW(1'b1)) i_duty (
    .clk(clk), .rst_n(rst_n), .ctl(duty_ctl), .wdata(bus_wdata), .load(cnt_load),
    .committed(duty_commit), .active(duty_active)
  );

  count_snap_reader #(.BYTE_W(BYTE_W)) i_snap (
    .clk(clk), .rst_n(rst_n), .snap(snap_hi),
    .live_lo(live_count[BYTE_W-1:0]), .held_lo(held_lo)
  );

  function automatic logic [WORD_W-1:0] pick(input logic [WORD_W-1:0] full,
                                             input logic hi, input logic wide);
    if (wide) return full;
    if (hi)   return {{BYTE_W{1'b0}}, full[WORD_W-1:BYTE_W]};
    return {{BYTE_W{1'b0}}, full[BYTE_W-1:0]};
  endfunction

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_CYC_HI:  rd_next = pick(cycle_val, 1'b1, bus_wide);
      A_CYC_LO:  rd_next = pick(cycle_val, 1'b0, 1'b0);
      A_DUTY_HI: rd_next = pick(duty_commit, 1'b1, bus_wide);
      A_DUTY_LO: rd_next = pick(duty_commit, 1'b0, 1'b0);
      A_CNT_HI:  rd_next = pick(live_count, 1'b1, bus_wide);
      A_CNT_LO:  rd_next = {{BYTE_W{1'b0}}, held_lo};
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (bus_rd) rd_data <= rd_next;
  end

  logic unused_ok;
  assign unused_ok = ^cyc_active_unused;
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int WORD_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [rb_pkg::ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0]         bus_wdata,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic                      bus_wide,
  input logic [WORD_W-1:0]         live_count,
  input logic                      cnt_load,
  input logic [WORD_W-1:0]         rd_data,
  input logic [WORD_W-1:0]         cycle_val,
  input logic [WORD_W-1:0]         duty_active,
  input logic [WORD_W-1:0]         duty_commit
);
  import rb_pkg::*;

  AST_HI_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wide && bus_addr == A_CYC_HI) |=> $stable(cycle_val)); // R2

  AST_WIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wide && bus_addr == A_CYC_HI) |=> (cycle_val == $past(bus_wdata))); // R3

  AST_WIDE_CNT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wide && bus_addr == A_CNT_HI) |=> (rd_data == $past(live_count))); // R4

  AST_CNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CNT_LO))
      |=> ($stable(cycle_val) && $stable(duty_commit))); // R5

  AST_DUTY_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_load |=> $stable(duty_active)); // R6

  AST_DUTY_LOAD_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (duty_active == $past(duty_commit))); // R6

  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rd_data)); // R9
endmodule

bind cnt_reg_bridge rb_checker #(.WORD_W(WORD_W)) i_rb_checker (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wide(bus_wide), .live_count(live_count),
  .cnt_load(cnt_load), .rd_data(rd_data), .cycle_val(cycle_val),
  .duty_active(duty_active), .duty_commit(duty_commit)
);

// File: tb/test_cnt_reg_bridge.sv
module test_cnt_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_wide = 1'b0, cnt_load = 1'b0;
  logic [15:0] live_count = '0;
  logic [15:0] rd_data, cycle_val, duty_active;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cnt_reg_bridge #(.WORD_W(16)) i_cnt_reg_bridge (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wide(bus_wide), .live_count(live_count),
    .cnt_load(cnt_load), .rd_data(rd_data), .cycle_val(cycle_val),
    .duty_active(duty_active)
  );

  typedef struct packed {
    logic wr; logic rd; logic wide; logic ld;
    logic [2:0] addr;
    logic [15:0] wd; logic [15:0] live;
    logic [15:0] e_cyc; logic [15:0] e_duty; logic [15:0] e_rd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [0:NV-1] = '{
    '{1,0,1,0,3'd0,16'h1234,16'h0000,16'h1234,16'hFFFF,16'h0000,4'd3}, // R3 wide write period
    '{1,0,0,0,3'd0,16'h0056,16'h0000,16'h1234,16'hFFFF,16'h0000,4'd2}, // R2 upper byte staged only
    '{1,0,0,0,3'd1,16'h0078,16'h0000,16'h5678,16'hFFFF,16'h0000,4'd2}, // R2 lower byte commits
    '{1,0,0,0,3'd1,16'h009A,16'h0000,16'h569A,16'hFFFF,16'h0000,4'd8}, // R8 lone lower byte
    '{1,0,0,0,3'd2,16'h0000,16'h0000,16'h569A,16'hFFFF,16'h0000,4'd2}, // R2 duty upper staged
    '{1,0,0,0,3'd3,16'h0040,16'h0000,16'h569A,16'hFFFF,16'h0000,4'd6}, // R6 commit, no load
    '{0,0,0,1,3'd0,16'h0000,16'h0000,16'h569A,16'h0040,16'h0000,4'd6}, // R6 load moves duty
    '{1,0,0,0,3'd2,16'h0001,16'h0000,16'h569A,16'h0040,16'h0000,4'd7}, // R7 upper byte
    '{0,0,0,1,3'd0,16'h0000,16'h0000,16'h569A,16'h0040,16'h0000,4'd7}, // R7 load mid-update keeps old
    '{1,0,0,0,3'd3,16'h0080,16'h0000,16'h569A,16'h0040,16'h0000,4'd7}, // R7 lower byte
    '{0,0,0,1,3'd0,16'h0000,16'h0000,16'h569A,16'h0180,16'h0000,4'd7}, // R7 next load new value
    '{0,1,0,0,3'd0,16'h0000,16'h0000,16'h569A,16'h0180,16'h0056,4'd9}, // R9 byte read upper
    '{0,1,0,0,3'd1,16'h0000,16'h0000,16'h569A,16'h0180,16'h009A,4'd9}, // R9 byte read lower
    '{0,1,1,0,3'd2,16'h0000,16'h0000,16'h569A,16'h0180,16'h0180,4'd3}, // R3 wide read duty
    '{0,1,0,0,3'd4,16'h0000,16'hABCD,16'h569A,16'h0180,16'h00AB,4'd4}, // R4 count upper snap
    '{0,1,0,0,3'd5,16'h0000,16'h1111,16'h569A,16'h0180,16'h00CD,4'd4}, // R4 held lower byte
    '{0,1,1,0,3'd4,16'h0000,16'hBEEF,16'h569A,16'h0180,16'hBEEF,4'd3}, // R3 wide count read
    '{1,0,1,0,3'd4,16'h7777,16'h0000,16'h569A,16'h0180,16'hBEEF,4'd5}, // R5 wide write count
    '{1,0,0,0,3'd5,16'h0033,16'h0000,16'h569A,16'h0180,16'hBEEF,4'd5}, // R5 byte write count
    '{0,1,0,0,3'd5,16'h0000,16'h2222,16'h569A,16'h0180,16'h00CD,4'd5}, // R5 R4 held byte intact
    '{1,0,0,0,3'd2,16'h0022,16'h0000,16'h569A,16'h0180,16'h00CD,4'd6}, // R6 duty upper
    '{1,0,0,1,3'd3,16'h0033,16'h0000,16'h569A,16'h0180,16'h00CD,4'd6}, // R6 write+load same clock
    '{0,1,0,1,3'd6,16'h0000,16'h0000,16'h569A,16'h2233,16'h0000,4'd9}  // R9 unmapped, R6 load
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [15:0] c, input logic [15:0] d,
                           input logic [15:0] r);
    check({tag, " cycle_val"}, cycle_val, c);
    check({tag, " duty_active"}, duty_active, d);
    check({tag, " rd_data"}, rd_data, r);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset", 16'hFFFF, 16'hFFFF, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release", 16'hFFFF, 16'hFFFF, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      bus_wr = VECS[i].wr; bus_rd = VECS[i].rd; bus_wide = VECS[i].wide;
      cnt_load = VECS[i].ld; bus_addr = VECS[i].addr;
      bus_wdata = VECS[i].wd; live_count = VECS[i].live;
      @(negedge clk);
      check_all($sformatf("R%0d vec%0d", VECS[i].req, i),
                VECS[i].e_cyc, VECS[i].e_duty, VECS[i].e_rd);
      bus_wr = 1'b0; bus_rd = 1'b0; bus_wide = 1'b0; cnt_load = 1'b0;
    end

    // R1: reset in mid-run restores all values, including the held count byte
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 mid-run reset", 16'hFFFF, 16'hFFFF, 16'h0000);
    bus_rd = 1'b1; bus_addr = 3'd5; live_count = 16'h4444;
    @(negedge clk);
    check("R1 held byte cleared", rd_data, 16'h0000);
    bus_rd = 1'b1; bus_addr = 3'd2; bus_wide = 1'b1;
    @(negedge clk);
    check("R1 committed duty reset", rd_data, 16'hFFFF);
    bus_rd = 1'b0; bus_wide = 1'b0;

    // R8: after reset, a lone lower byte keeps the reset upper byte
    bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 16'h0011;
    @(negedge clk);
    check("R8 lone lower after reset", cycle_val, 16'hFF11);
    // R2: staged byte is not readable before commit
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0099;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 3'd0;
    @(negedge clk);
    check("R2 read returns committed upper", rd_data, 16'h00FF);
    bus_rd = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule